// File: doc/BRIEF.md
# Beam-Steering Weight Sequencer

This block turns a pair of steering angles into per-element weights for a 16-element planar array and delivers them serially to four four-channel beamformer devices. A one-cycle start strobe captures a signed azimuth and elevation in whole degrees. The block clamps each angle to ±45 degrees and looks up its sine in a table it builds itself. It then visits the elements in ascending order. For each element it computes a 6-bit phase code from the element's grid position and a 7-bit gain code from a separable amplitude taper.

Each element's weight goes out as one 24-bit SPI frame that carries the target device and channel. After the last frame has ended, a done pulse tells the controlling logic that the array holds the new beam. Element positions are held in units of one sixty-fourth of a wavelength. The product of position and scaled sine therefore lands directly in phase-code units, and the wrap to one turn is a plain truncation to the low six bits.

Top module: `bsw_beam_seq`

## Requirements
- R1: Elements are sent in ascending order 0 to 15; the device field of each frame is element/4 and the channel field is element%4.
- R2: Element e sits at x = (e%4)·32 and y = (e/4)·32 in units of λ/64. Its phase code is floor((x·Saz + y·Sel)/256) taken modulo 64, where Saz and Sel are the scaled sines of the two angles.
- R3: The scaled sine of an angle a in degrees is sign(a)·floor(1024·p/(40500−p)) with p = |a|·(180−|a|), a scale of 256 for a full unit.
- R4: An angle outside −45..+45 degrees is used as the nearest limit, −45 or +45.
- R5: Each frame is 24 bits sent MSB first: bits 23:22 device, 21:20 channel, 19:14 phase, 13:7 gain, 6:0 zero. Chip select is low for the whole frame, the clock idles low, and data is stable while the clock is high and is sampled on its rising edge.
- R6: The gain code is (wc·wr)>>7. Here wc is 76 for an edge column (0 or 3) and 127 otherwise, and wr is the same for the row. This gives 45 at corners, 75 on edges and 126 in the centre.
- R7: After a start, exactly 16 frames are sent. done rises for one clock cycle only after chip select has returned high following the 16th frame.
- R8: A start strobe that arrives while a sequence is running changes neither the weights of that sequence nor the number of frames, and starts no new sequence.
- R9: While in reset and directly after it, chip select is high, the SPI clock is low and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to steer the beam |
| az_i | input | 7 | Azimuth in signed whole degrees |
| el_i | input | 7 | Elevation in signed whole degrees |
| spi_sclk_o | output | 1 | SPI serial clock, idles low |
| spi_mosi_o | output | 1 | SPI serial data out |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| done_o | output | 1 | One-cycle pulse when all weights are sent |

## Verification
The bench steers along boresight, along each axis alone at both limits, and to mixed-sign angle pairs. It also runs an azimuth sweep in 9-degree steps at a fixed elevation. Single-axis cases isolate the column term from the row term, and mixed-sign pairs exercise negative phase sums and their wrap modulo 64. Out-of-range angles such as +60 and −64 must produce frames identical to the ±45 limits, which separates correct clamping from table overrun. A second start issued mid-sequence must leave all 16 frames and the single done pulse unchanged.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    localparam int NUM_ELEM   = 16;
    localparam int COLS       = 4;
    localparam int CH_PER_DEV = 4;
    localparam int EL_W       = $clog2(NUM_ELEM);
    localparam int COL_W      = $clog2(COLS);
    localparam int CH_W       = $clog2(CH_PER_DEV);
    localparam int DEV_W      = EL_W - CH_W;
    localparam int PHASE_W    = 6;
    localparam int GAIN_W     = 7;
    localparam int RSVD_W     = 7;
    localparam int FRAME_W    = DEV_W + CH_W + PHASE_W + GAIN_W + RSVD_W;
    localparam int ANG_W      = 7;
    localparam int MAX_DEG    = 45;
    localparam int SIN_FRAC   = 8;
    localparam int MAG_W      = SIN_FRAC + 1;
    localparam int SPACING    = 32;
    localparam int W_EDGE     = 76;
    localparam int W_CENTER   = 127;

    typedef struct packed {
        logic [DEV_W-1:0]   dev;
        logic [CH_W-1:0]    ch;
        logic [PHASE_W-1:0] phase;
        logic [GAIN_W-1:0]  gain;
        logic [RSVD_W-1:0]  rsvd;
    } frame_t;
endpackage

// File: rtl/bsw_sine.sv
module bsw_sine
    import bsw_pkg::*;
(
    input  logic signed [ANG_W-1:0] ang_i,
    output logic signed [MAG_W:0]   sin_o
);
    localparam int IDX_W = $clog2(MAX_DEG + 1);

    function automatic logic [MAX_DEG:0][MAG_W-1:0] build_tab();
        logic [MAX_DEG:0][MAG_W-1:0] t;
        int p;
        for (int d = 0; d <= MAX_DEG; d++) begin
            p    = d * (180 - d);
            t[d] = MAG_W'((4 * (1 << SIN_FRAC) * p) / (40500 - p));
        end
        return t;
    endfunction

    localparam logic [MAX_DEG:0][MAG_W-1:0] SIN_TAB = build_tab();

    logic signed [ANG_W:0] a_ext;
    logic signed [ANG_W:0] mag;
    logic [IDX_W-1:0]      idx;
    logic signed [MAG_W:0] val;

    always_comb begin
        a_ext = (ANG_W+1)'(ang_i);
        mag   = (a_ext < 0) ? -a_ext : a_ext;
        if (mag > $signed((ANG_W+1)'(MAX_DEG))) begin
            mag = $signed((ANG_W+1)'(MAX_DEG));
        end
        idx   = mag[IDX_W-1:0];
        val   = $signed({1'b0, SIN_TAB[idx]});
        sin_o = (a_ext < 0) ? -val : val;
    end
endmodule

// File: rtl/bsw_weight.sv
module bsw_weight
    import bsw_pkg::*;
(
    input  logic [EL_W-1:0]      elem_i,
    input  logic signed [MAG_W:0] sin_az_i,
    input  logic signed [MAG_W:0] sin_el_i,
    output frame_t               frame_o
);
    localparam int ACC_W = 24;
    localparam int ROW_W = EL_W - COL_W;
    localparam int ROWS  = NUM_ELEM / COLS;

    logic [COL_W-1:0]      col;
    logic [ROW_W-1:0]      row;
    logic signed [ACC_W-1:0] x_s, y_s, acc, shifted;
    logic [7:0]            wc, wr;
    logic [15:0]           wprod;

    always_comb begin
        col     = elem_i[COL_W-1:0];
        row     = elem_i[EL_W-1:COL_W];
        x_s     = $signed(ACC_W'(col) * ACC_W'(SPACING));
        y_s     = $signed(ACC_W'(row) * ACC_W'(SPACING));
        acc     = x_s * ACC_W'(sin_az_i) + y_s * ACC_W'(sin_el_i);
        shifted = acc >>> SIN_FRAC;

        wc = (col == '0 || col == COL_W'(COLS - 1)) ? 8'(W_EDGE) : 8'(W_CENTER);
        wr = (row == '0 || row == ROW_W'(ROWS - 1)) ? 8'(W_EDGE) : 8'(W_CENTER);
        wprod = 16'(wc) * 16'(wr);

        frame_o.dev   = elem_i[EL_W-1:CH_W];
        frame_o.ch    = elem_i[CH_W-1:0];
        frame_o.phase = shifted[PHASE_W-1:0];
        frame_o.gain  = wprod[GAIN_W+6:7];
        frame_o.rsvd  = '0;
    end
endmodule

// File: rtl/bsw_spi_tx.sv
module bsw_spi_tx #(
    parameter int FRAME_W  = 24,
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               cs_n_o,
    output logic               done_o
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam int BIT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               active;
        logic               sclk;
        logic               cs_n;
        logic               done;
        logic [FRAME_W-1:0] sh;
        logic [BIT_W-1:0]   bitn;
        logic [DIV_W-1:0]   div;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (go_i) begin
                d.active = 1'b1;
                d.cs_n   = 1'b0;
                d.sclk   = 1'b0;
                d.sh     = frame_i;
                d.bitn   = '0;
                d.div    = '0;
            end
        end else if (q.div == DIV_W'(HALF_DIV - 1)) begin
            d.div = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
            end else begin
                d.sclk = 1'b0;
                if (q.bitn == BIT_W'(FRAME_W - 1)) begin
                    d.active = 1'b0;
                    d.cs_n   = 1'b1;
                    d.done   = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.sh   = q.sh << 1;
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign mosi_o = q.sh[FRAME_W-1];
    assign cs_n_o = q.cs_n;
    assign done_o = q.done;
endmodule

// File: rtl/bsw_beam_seq.sv
module bsw_beam_seq
    import bsw_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ANG_W-1:0] az_i,
    input  logic [ANG_W-1:0] el_i,
    output logic             spi_sclk_o,
    output logic             spi_mosi_o,
    output logic             spi_cs_n_o,
    output logic             done_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} st_e;

    typedef struct packed {
        st_e                   st;
        logic [EL_W-1:0]       elem;
        logic signed [MAG_W:0] saz;
        logic signed [MAG_W:0] sel;
        logic                  go;
        logic                  done;
    } seq_t;

    seq_t q, d;
    logic signed [MAG_W:0] saz_w, sel_w;
    frame_t                frame_w;
    logic                  spi_done_w;

    bsw_sine u_sin_az (.ang_i($signed(az_i)), .sin_o(saz_w));
    bsw_sine u_sin_el (.ang_i($signed(el_i)), .sin_o(sel_w));

    bsw_weight u_weight (
        .elem_i   (q.elem),
        .sin_az_i (q.saz),
        .sin_el_i (q.sel),
        .frame_o  (frame_w)
    );

    bsw_spi_tx #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (q.go),
        .frame_i (frame_w),
        .sclk_o  (spi_sclk_o),
        .mosi_o  (spi_mosi_o),
        .cs_n_o  (spi_cs_n_o),
        .done_o  (spi_done_w)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.saz  = saz_w;
                    d.sel  = sel_w;
                    d.elem = '0;
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.go = 1'b1;
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (spi_done_w) begin
                    if (q.elem == EL_W'(NUM_ELEM - 1)) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.elem = q.elem + 1'b1;
                        d.st   = ST_LOAD;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
endmodule

// File: rtl/bsw_beam_seq_chk.sv
module bsw_beam_seq_chk
    import bsw_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic done
);
    logic       cs_q, sclk_q;
    logic [5:0] bitc;
    logic [5:0] frc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            bitc   <= '0;
            frc    <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (cs_q && !cs_n) begin
                bitc <= '0;
            end else if (!cs_n && sclk && !sclk_q) begin
                bitc <= bitc + 1'b1;
            end
            if (done) begin
                frc <= '0;
            end else if (cs_n && !cs_q) begin
                frc <= frc + 1'b1;
            end
        end
    end

    // R5: clock idles low whenever the device is deselected
    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5: data does not move while the clock is high
    assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk) |-> $stable(mosi));

    // R5: every frame holds exactly FRAME_W clock rises
    assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_q) |-> (bitc == 6'(FRAME_W)));

    // R7: done only while deselected and after all elements
    assert_done_after_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && frc == 6'(NUM_ELEM)));

    // R7: done lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind bsw_beam_seq bsw_beam_seq_chk i_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (spi_sclk_o),
    .mosi (spi_mosi_o),
    .cs_n (spi_cs_n_o),
    .done (done_o)
);

// File: tb/test_bsw_beam_seq.sv
module test_bsw_beam_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] az = '0;
    logic [6:0] el = '0;
    logic       sclk, mosi, cs_n, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bsw_beam_seq i_bsw_beam_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .az_i      (az),
        .el_i      (el),
        .spi_sclk_o(sclk),
        .spi_mosi_o(mosi),
        .spi_cs_n_o(cs_n),
        .done_o    (done)
    );

    logic [23:0] rx_sh;
    int          rx_bits = 0;
    logic        armed = 1'b0;
    logic [23:0] frames [16];
    int          nfr = 0;
    int          ndone = 0;
    int          nfr_at_done = 0;

    always @(negedge cs_n) begin
        armed   = 1'b1;
        rx_bits = 0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            rx_sh   = {rx_sh[22:0], mosi};
            rx_bits = rx_bits + 1;
        end
    end

    always @(posedge cs_n) begin
        if (armed) begin
            armed  = 1'b0;
            checks = checks + 1;
            if (rx_bits != 24) begin
                errors = errors + 1;
                $display("FAIL R5 frame length: got %0d expected 24", rx_bits);
            end
            if (nfr < 16) frames[nfr] = rx_sh;
            nfr = nfr + 1;
        end
    end

    always @(posedge clk) begin
        if (rst_n && done === 1'b1) begin
            ndone       <= ndone + 1;
            nfr_at_done <= nfr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int sine_ref(input int a);
        int m, p, v;
        if (a > 45) a = 45;
        if (a < -45) a = -45;
        m = (a < 0) ? -a : a;
        p = m * (180 - m);
        v = (1024 * p) / (40500 - p);
        return (a < 0) ? -v : v;
    endfunction

    function automatic logic [23:0] exp_frame(input int e, input int a, input int b);
        int col, row, acc, ph, wc, wr, g;
        col = e % 4;
        row = e / 4;
        acc = (col * 32) * sine_ref(a) + (row * 32) * sine_ref(b);
        ph  = (acc >>> 8) & 63;
        wc  = (col == 0 || col == 3) ? 76 : 127;
        wr  = (row == 0 || row == 3) ? 76 : 127;
        g   = (wc * wr) >> 7;
        return {2'(e / 4), 2'(e % 4), 6'(ph), 7'(g), 7'b0};
    endfunction

    task automatic pulse_start(input int a, input int b);
        @(negedge clk);
        az    = 7'(a);
        el    = 7'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        int t = 0;
        while (ndone == d0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, "R7 done seen", t, 0);
    endtask

    task automatic compare(input int a, input int b, input int d0, input string tag);
        check(ndone == d0 + 1, "R7 single done", ndone - d0, 1);
        check(nfr_at_done == 16, "R7 frames before done", nfr_at_done, 16);
        for (int e = 0; e < 16; e++) begin
            logic [23:0] x;
            x = exp_frame(e, a, b);
            check(frames[e] == x, tag, int'(frames[e]), int'(x));
        end
    endtask

    task automatic run(input int a, input int b, input int ea, input int eb, input string tag);
        int d0;
        d0  = ndone;
        nfr = 0;
        pulse_start(a, b);
        wait_done(d0);
        @(negedge clk);
        compare(ea, eb, d0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(cs_n === 1'b1, "R9 cs_n in reset", int'(cs_n), 1);
        check(sclk === 1'b0, "R9 sclk in reset", int'(sclk), 0);
        check(done === 1'b0, "R9 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b0 && done === 1'b0, "R9 idle after reset",
              int'({cs_n, sclk, done}), 4);

        // R1 R2 R6: boresight, only taper and addressing visible
        run(0, 0, 0, 0, "R1 R6 boresight frame");
        // R2 R3: single axis at both limits
        run(45, 0, 45, 0, "R2 R3 az +45 frame");
        run(-45, 0, -45, 0, "R2 R3 az -45 frame");
        run(0, 45, 0, 45, "R2 R3 el +45 frame");
        run(0, -45, 0, -45, "R2 R3 el -45 frame");
        // R2: mixed signs, wrap of negative sums
        run(30, -20, 30, -20, "R2 mixed frame");
        run(-17, 33, -17, 33, "R2 mixed frame");
        run(7, 7, 7, 7, "R2 small frame");
        run(-45, -45, -45, -45, "R2 corner frame");
        // R4: clamping of out-of-range angles
        run(60, -64, 45, -45, "R4 clamp frame");
        run(63, 50, 45, 45, "R4 clamp frame");
        run(-46, 46, -45, 45, "R4 clamp edge frame");
        // R3: azimuth sweep
        for (int a = -45; a <= 45; a += 9) begin
            run(a, 12, a, 12, "R3 sweep frame");
        end

        // R8: second start mid-sequence is ignored
        begin
            int d0;
            d0  = ndone;
            nfr = 0;
            pulse_start(20, -10);
            while (nfr < 3) @(negedge clk);
            pulse_start(-30, 40);
            wait_done(d0);
            @(negedge clk);
            compare(20, -10, d0, "R8 busy start frame");
            repeat (300) @(negedge clk);
            check(nfr == 16, "R8 no extra frames", nfr, 16);
            check(ndone == d0 + 1, "R8 no extra done", ndone - d0, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule